// File: doc/BRIEF.md
# Cell Header Arbitration Unit

This block is the control half of a four-port cell switch. A frame-start pulse opens each frame. The block picks up the header byte presented on each of the four input lanes, decodes it, and decides which input each output port will carry for the rest of the frame. The data crossbar and any cell buffering sit outside this block. They consume the per-output grant index and the output-disable flag that this unit holds in registers.

Each header says three things: whether the cell is live, whether it is urgent, and which output it wants. For every output, urgent requests hide ordinary ones. A round-robin arbiter then chooses one input from the remaining candidates. The work is sequenced by a three-state machine:

- **IDLE_WAIT** is left for **ROUTE** (transition *capture*) on the first cycle that frame start is low. The headers are latched on that cycle.
- **ROUTE** goes to **RUN** (transition *commit*) when frame start stays low, and the grant registers are written at that point.
- **ROUTE** falls back to **IDLE_WAIT** (transition *abort*) if frame start rises, and the grants are left untouched.
- **RUN** stays in **RUN** (transition *hold*) while frame start is low, and returns to **IDLE_WAIT** (transition *restart*) when it rises.
- **IDLE_WAIT** stays in **IDLE_WAIT** (transition *idle*) while frame start is high.

Top module: `cell_arb_top`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in IDLE_WAIT. It sets every bit of `out_off`, clears `x_grant` and `y_grant`, and points every round-robin pointer at input 3, so input 0 is searched first.
- R2: Header lane i is `hdr_i[8*i+7:8*i]`. Bit 0 is the live flag, bit 1 is the urgent flag, and bits 3:2 give the destination output number. Bits 7:4 have no effect on any output.
- R3: In IDLE_WAIT with `frame_start` low, the headers are latched and the next state is ROUTE, so `route_en` is high in the following cycle.
- R4: While `frame_start` is high, `route_en` is low. A ROUTE cycle with `frame_start` high returns to IDLE_WAIT and leaves all grant outputs unchanged.
- R5: ROUTE with `frame_start` low moves to RUN. RUN holds while `frame_start` is low and returns to IDLE_WAIT when it is high.
- R6: For an output that has at least one live urgent request, live non-urgent requests for that output are dropped before arbitration.
- R7: The winner index of output o is carried as `x_grant[o]` (bit 0) and `y_grant[o]` (bit 1). `out_off[o]` is 1 when output o has no candidate, and in that case both grant bits are 0.
- R8: Each output arbiter searches from the input after its last winner, in increasing order with wrap. The pointer moves only when a winner is chosen.
- R9: The grant outputs change only on the clock edge that ends a cycle with `route_en` high. They are stable in every other cycle.
- R10: `route_en` is high exactly when the sequencer is in ROUTE and `frame_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame boundary pulse |
| hdr_i | input | 32 | Four header lanes, lane i at bits 8*i+7:8*i |
| route_en | output | 1 | High in the cycle the grants are computed |
| x_grant | output | 4 | Bit 0 of each output's winner index |
| y_grant | output | 4 | Bit 1 of each output's winner index |
| out_off | output | 4 | Output has no winner this frame |

## Verification
The properties assume that `frame_start` is a clean synchronous level. They also assume that header lanes only matter in the cycle the sequencer leaves IDLE_WAIT. Nothing is assumed about header values, so the bench drives headers with arbitrary unused bits and changes them freely during RUN. The bench toggles `frame_start` only on the falling clock edge. It covers every state transition, including an abort out of ROUTE and long RUN holds with changing headers. A behavioural reference model is compared with the outputs on every cycle.

// File: rtl/cell_arb_pkg.sv
package cell_arb_pkg;
    localparam int N_PORT = 4;
    localparam int HDR_W  = 8;
    localparam int IDX_W  = $clog2(N_PORT);
    localparam int LIVE_B = 0;
    localparam int URG_B  = 1;
    localparam int DST_LO = 2;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ROUTE = 2'd1,
        ST_RUN   = 2'd2
    } arb_state_e;
endpackage

// File: rtl/cell_arb_seq.sv
module cell_arb_seq
    import cell_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    output arb_state_e state_o,
    output logic       capture_o,
    output logic       route_en_o
);
    arb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (!frame_start) state_d = ST_ROUTE;
            ST_ROUTE: state_d = frame_start ? ST_WAIT : ST_RUN;
            ST_RUN:   if (frame_start) state_d = ST_WAIT;
            default:  state_d = ST_WAIT;
        endcase
    end

    always_comb begin
        capture_o  = 1'b0;
        route_en_o = 1'b0;
        unique case (state_q)
            ST_WAIT:  capture_o  = !frame_start;
            ST_ROUTE: route_en_o = !frame_start;
            ST_RUN:   ;
            default:  ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/cell_arb_filter.sv
module cell_arb_filter
    import cell_arb_pkg::*;
#(
    parameter int NP = N_PORT,
    parameter int HW = HDR_W,
    parameter int IW = IDX_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   capture,
    input  logic [NP*HW-1:0]       hdr_i,
    output logic [NP-1:0][NP-1:0]  req_o
);
    localparam int KEEP_W = DST_LO + IW;

    logic [NP-1:0][KEEP_W-1:0] hdr_q;
    logic [NP-1:0][HW-KEEP_W-1:0] hdr_unused;

    for (genvar i = 0; i < NP; i++) begin : g_lane
        assign hdr_unused[i] = hdr_i[i*HW+KEEP_W +: HW-KEEP_W];
        always_ff @(posedge clk) begin
            if (rst)          hdr_q[i] <= '0;
            else if (capture) hdr_q[i] <= hdr_i[i*HW +: KEEP_W];
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        logic [NP-1:0] all_r, urg_r;
        for (genvar i = 0; i < NP; i++) begin : g_in
            assign all_r[i] = hdr_q[i][LIVE_B] &&
                              (hdr_q[i][DST_LO +: IW] == IW'(o));
            assign urg_r[i] = all_r[i] && hdr_q[i][URG_B];
        end
        assign req_o[o] = (|urg_r) ? urg_r : all_r;
    end
endmodule

// File: rtl/cell_arb_rr.sv
module cell_arb_rr
    import cell_arb_pkg::*;
#(
    parameter int NP = N_PORT,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [NP-1:0] req,
    output logic [IW-1:0] idx_o,
    output logic          off_o
);
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] pick;
    logic          found;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= NP; k++) begin
            int c;
            c = (int'(ptr_q) + k) % NP;
            if (!found && req[c]) begin
                found = 1'b1;
                pick  = IW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= IW'(NP - 1);
            idx_o <= '0;
            off_o <= 1'b1;
        end else if (upd) begin
            off_o <= !found;
            idx_o <= found ? pick : '0;
            if (found) ptr_q <= pick;
        end
    end
endmodule

// File: rtl/cell_arb_top.sv
module cell_arb_top
    import cell_arb_pkg::*;
#(
    parameter int NP = N_PORT,
    parameter int HW = HDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic [NP*HW-1:0]   hdr_i,
    output logic               route_en,
    output logic [NP-1:0]      x_grant,
    output logic [NP-1:0]      y_grant,
    output logic [NP-1:0]      out_off
);
    localparam int IW = $clog2(NP);

    arb_state_e             state;
    logic                   capture;
    logic [NP-1:0][NP-1:0]  req;
    logic [NP-1:0][IW-1:0]  idx;

    cell_arb_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .state_o    (state),
        .capture_o  (capture),
        .route_en_o (route_en)
    );

    cell_arb_filter #(.NP(NP), .HW(HW), .IW(IW)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .capture(capture),
        .hdr_i  (hdr_i),
        .req_o  (req)
    );

    for (genvar o = 0; o < NP; o++) begin : g_arb
        cell_arb_rr #(.NP(NP), .IW(IW)) u_rr (
            .clk  (clk),
            .rst  (rst),
            .upd  (route_en),
            .req  (req[o]),
            .idx_o(idx[o]),
            .off_o(out_off[o])
        );
        assign x_grant[o] = idx[o][0];
        assign y_grant[o] = idx[o][IW-1];
    end
endmodule

// File: rtl/cell_arb_chk.sv
module cell_arb_chk
    import cell_arb_pkg::*;
#(
    parameter int NP = N_PORT
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_start,
    input arb_state_e    state,
    input logic          route_en,
    input logic [NP-1:0] x_grant,
    input logic [NP-1:0] y_grant,
    input logic [NP-1:0] out_off
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_WAIT && out_off == '1 && x_grant == '0 && y_grant == '0));

    p_wait_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !frame_start) |=> (state == ST_ROUTE));

    p_start_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !route_en);

    p_route_abort_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROUTE && frame_start) |=> (state == ST_WAIT));

    p_route_commit_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROUTE && !frame_start) |=> (state == ST_RUN));

    p_run_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !frame_start) |=> (state == ST_RUN));

    p_off_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ((x_grant & out_off) == '0 && (y_grant & out_off) == '0));

    p_grant_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !route_en |=> $stable({x_grant, y_grant, out_off}));
endmodule

bind cell_arb_top cell_arb_chk #(.NP(NP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .state      (state),
    .route_en   (route_en),
    .x_grant    (x_grant),
    .y_grant    (y_grant),
    .out_off    (out_off)
);

// File: tb/cell_arb_top_tb_top.sv
module cell_arb_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fs  = 1'b0;
    logic [31:0] din = '0;
    wire         ren;
    wire [3:0]   xg, yg, off;

    always #4 clk = ~clk;

    cell_arb_top dut_i (
        .clk(clk), .rst(rst), .frame_start(fs), .hdr_i(din),
        .route_en(ren), .x_grant(xg), .y_grant(yg), .out_off(off)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    int m_state;
    int m_x[4], m_y[4], m_off[4], m_ptr[4];
    logic [7:0] m_hdr[4];

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0;
            for (int o = 0; o < 4; o++) begin
                m_x[o] = 0; m_y[o] = 0; m_off[o] = 1; m_ptr[o] = 3;
            end
        end else if (m_state == 0) begin
            if (!fs) begin
                for (int i = 0; i < 4; i++) m_hdr[i] = din[i*8 +: 8];
                m_state = 1;
            end
        end else if (m_state == 1) begin
            if (fs) m_state = 0;
            else begin
                for (int o = 0; o < 4; o++) begin
                    bit urg, hit;
                    urg = 0; hit = 0;
                    for (int i = 0; i < 4; i++)
                        if (m_hdr[i][0] && m_hdr[i][3:2] == o && m_hdr[i][1]) urg = 1;
                    for (int k = 1; k <= 4; k++) begin
                        int i;
                        i = (m_ptr[o] + k) % 4;
                        if (!hit && m_hdr[i][0] && m_hdr[i][3:2] == o && (!urg || m_hdr[i][1])) begin
                            hit = 1; m_ptr[o] = i;
                        end
                    end
                    m_off[o] = hit ? 0 : 1;
                    m_x[o] = hit ? (m_ptr[o] & 1) : 0;
                    m_y[o] = hit ? (m_ptr[o] >> 1) : 0;
                end
                m_state = 2;
            end
        end else if (fs) m_state = 0;
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        for (int o = 0; o < 4; o++) begin
            chk("R7 x_grant vs model", int'(xg[o]), m_x[o]);
            chk("R7 y_grant vs model", int'(yg[o]), m_y[o]);
            chk("R7 out_off vs model", int'(off[o]), m_off[o]);
        end
        chk("R10 route_en vs model", int'(ren), (m_state == 1 && !fs) ? 1 : 0);
    endtask

    task automatic tick(bit f, logic [31:0] d);
        @(negedge clk);
        cmp_model();
        fs = f; din = d;
    endtask

    function automatic logic [7:0] hd(bit live, bit urg, int dst);
        return {4'h0, 2'(dst), urg, live};
    endfunction

    task automatic grant(int o, int idx, int exp_off, string tag);
        chk(tag, int'(off[o]), exp_off);
        chk(tag, int'({yg[o], xg[o]}), exp_off ? 0 : idx);
    endtask

    task automatic frame(logic [31:0] d);
        tick(1'b1, '0);
        tick(1'b0, d);
        tick(1'b0, '0);
        #1 chk("R3 route_en after capture", int'(ren), 1);
        tick(1'b0, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset out_off", int'(off), 15);
        chk("R1 reset x_grant", int'(xg), 0);
        chk("R1 reset y_grant", int'(yg), 0);
        chk("R1 reset route_en", int'(ren), 0);
        rst = 1'b0; fs = 1'b1;

        // in0 -> out2 plain, in1 -> out2 urgent, in2 idle with junk, in3 -> out1 with junk high bits
        frame({8'hA5, 8'hF4, hd(1, 1, 2), hd(1, 0, 2)});
        grant(2, 1, 0, "R6 urgent beats plain on out2");
        grant(1, 3, 0, "R2 route field and ignored high bits");
        grant(0, 0, 1, "R7 out0 idle");
        grant(3, 0, 1, "R7 out3 idle");

        for (int n = 0; n < 3; n++) begin
            frame({4{hd(1, 0, 0)}});
            grant(0, n, 0, "R8 rotation on out0");
        end
        frame({hd(1, 0, 0), 8'h00, 8'h00, hd(1, 0, 0)});
        grant(0, 3, 0, "R8 skip to in3");
        frame({hd(1, 0, 0), 8'h00, 8'h00, hd(1, 0, 0)});
        grant(0, 0, 0, "R8 wrap to in0");

        // abort out of ROUTE
        tick(1'b1, '0);
        tick(1'b0, {4{hd(1, 1, 3)}});
        tick(1'b1, '0);
        #1 chk("R4 route_en low under frame_start", int'(ren), 0);
        tick(1'b1, '0);
        grant(0, 0, 0, "R4 grants kept after abort");
        grant(3, 0, 1, "R4 out3 untouched after abort");

        frame({hd(1, 0, 1), hd(1, 0, 1), hd(1, 0, 1), hd(1, 0, 1)});
        grant(1, 0, 0, "R8 out1 after in3 wins in0");
        for (int n = 0; n < 6; n++) begin
            tick(1'b0, {4{8'h0B + 8'(n)}});
            #1 chk("R5 RUN holds, no route_en", int'(ren), 0);
        end
        tick(1'b0, '0);
        grant(1, 0, 0, "R9 grants stable through RUN");

        frame({8'h00, hd(1, 1, 2), hd(1, 0, 2), hd(1, 1, 2)});
        grant(2, 2, 0, "R6 R8 urgent group rotation on out2");
        tick(1'b1, '0);
        tick(1'b1, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule